// File: doc/BRIEF.md
# Flash Control Register Front End

This block sits between a simple single-cycle register bus and the sequencing logic of an embedded flash controller. It keeps the control word that selects program, page-erase or mass-erase, the page number and the start request, plus the two sticky status flags that report how an operation ended. Its outputs drive the flash sequencer directly and raise the end-of-operation and error interrupt requests.

Its main job is to decide what happens to a control-word write while the flash is not idle. If another agent holds the configuration busy and no suspend is in force, the write is stalled by holding ready low. If a suspend is in force and an operation is running, the write ends at once with an error response and changes nothing. If a suspend is in force but nothing is running, the write is accepted, but the requested operation is held back until the suspend is lifted. Lock-key handling and option loading are outside the block: two stub pulses clear the lock bits.

Top module: `fctl_regif`

## Requirements
- R1: After reset the control word at offset 0x14 reads 0xC000_0000, the status word at offset 0x10 reads 0, the bus is ready and no operation is launched.
- R2: A control-word write made while configuration-busy is 1 and suspend is 0 keeps bus_ready_o low. The control word is left unchanged until configuration-busy falls. The write then completes.
- R3: A control-word write made while suspend is 1 and an operation is running completes in the same cycle with bus_ready_o and bus_err_o both 1. The control word is left unchanged.
- R4: A control-word write made while suspend is 1 and no operation is running is accepted without error. A start requested this way keeps launch_o at 0 and busy_o at 1 until suspend falls. launch_o rises one clock after that.
- R5: The operation-error flag (status bit 1) is set by an op_fail_i pulse only when ERRIE (control bit 25) is 1. Writing 1 to status bit 1 clears it.
- R6: The end-of-operation flag (status bit 0) is set by an op_ok_i pulse only when EOPIE (control bit 24) is 1. Writing 1 to status bit 0 clears it.
- R7: Control-word writes update only the bytes whose strobe in bus_be_i is 1. Strobe bit n covers data bits [8n+7:8n].
- R8: The control-word layout is PG bit 0, PER bit 1, MER bit 2, page number bits [9:3], START bit 16, EOPIE bit 24, ERRIE bit 25, OPTLOCK bit 30 and LOCK bit 31. prog_o, page_erase_o, mass_erase_o and page_num_o follow PG, PER, MER and the page number.
- R9: START, OPTLOCK and LOCK can only be set by software, and writing 0 to them has no effect. START is cleared by op_ok_i or op_fail_i. LOCK is cleared by unlock_i and OPTLOCK by opt_unlock_i.
- R10: Reserved control bits read as 0 and ignore writes.
- R11: irq_eop_o is 1 while the end-of-operation flag and EOPIE are both 1. irq_err_o is 1 while the operation-error flag and ERRIE are both 1.
- R12: While LOCK is 1, writes to every control bit other than OPTLOCK and LOCK are ignored, and the write completes without error.
- R13: The status layout is end-of-operation bit 0, operation-error bit 1, busy bit 16, configuration-busy bit 17 and suspend bit 18. busy_o and status bit 16 are 1 while op_busy_i is 1 or START is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus request present |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte strobes |
| bus_ready_o | output | 1 | Request completes this cycle; low means stall |
| bus_err_o | output | 1 | Error response, valid when ready is 1 |
| bus_rdata_o | output | 32 | Read data for a read request |
| op_busy_i | input | 1 | Program or erase in progress |
| op_ok_i | input | 1 | Pulse: operation ended successfully |
| op_fail_i | input | 1 | Pulse: operation ended with an error |
| susp_i | input | 1 | Suspend in force |
| cfg_busy_i | input | 1 | Configuration held busy by another agent |
| unlock_i | input | 1 | Stub pulse: key sequence accepted, clears LOCK |
| opt_unlock_i | input | 1 | Stub pulse: option key accepted, clears OPTLOCK |
| prog_o | output | 1 | Program mode selected |
| page_erase_o | output | 1 | Page-erase mode selected |
| mass_erase_o | output | 1 | Mass-erase mode selected |
| page_num_o | output | PNB_W | Page selected for erase |
| launch_o | output | 1 | Start request released to the sequencer |
| busy_o | output | 1 | Operation running or pending |
| irq_eop_o | output | 1 | End-of-operation interrupt request |
| irq_err_o | output | 1 | Error interrupt request |

## Verification
The same control-word write is issued under four input states: idle, configuration-busy without suspend, suspend with an operation running, and suspend with the flash idle. The outcomes are a completed write, a stall, an error with no update, and an accepted write with a held start. Telling these apart shows that the stall, error and pending paths are each chosen by the right combination of inputs. Completion pulses are also tried with each interrupt enable both on and off, which shows whether flag setting depends on the enable. Writes with partial strobes, writes of zero to the set-only bits, and writes made while locked show which bits any write can reach.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned BE_W   = DATA_W / 8;

   // control word bit positions
   localparam int unsigned B_PG      = 0;
   localparam int unsigned B_PER     = 1;
   localparam int unsigned B_MER     = 2;
   localparam int unsigned B_PNB     = 3;
   localparam int unsigned B_STRT    = 16;
   localparam int unsigned B_EOPIE   = 24;
   localparam int unsigned B_ERRIE   = 25;
   localparam int unsigned B_OPTLOCK = 30;
   localparam int unsigned B_LOCK    = 31;

   // status word bit positions
   localparam int unsigned S_EOP    = 0;
   localparam int unsigned S_OPERR  = 1;
   localparam int unsigned S_BSY    = 16;
   localparam int unsigned S_CFGBSY = 17;
   localparam int unsigned S_SUSP   = 18;

   typedef enum logic [1:0] {
      WV_IDLE  = 2'd0,
      WV_STALL = 2'd1,
      WV_ERR   = 2'd2,
      WV_TAKE  = 2'd3
   } wr_verdict_e;
endpackage

// File: rtl/fctl_wr_gate.sv
module fctl_wr_gate
   import fctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CR_OFF = 'h14,
   parameter int unsigned SR_OFF = 'h10
) (
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cfg_busy_i,
   input  logic              susp_i,
   input  logic              op_busy_i,
   output logic              cr_we_o,
   output logic              sr_we_o,
   output logic              ready_o,
   output logic              err_o
);
   wr_verdict_e verdict;
   logic cr_hit, sr_hit;

   assign cr_hit = (addr_i == ADDR_W'(CR_OFF));
   assign sr_hit = (addr_i == ADDR_W'(SR_OFF));

   always_comb begin
      verdict = WV_IDLE;
      if (valid_i && write_i && cr_hit) begin
         if (susp_i) begin
            verdict = op_busy_i ? WV_ERR : WV_TAKE;
         end else if (cfg_busy_i) begin
            verdict = WV_STALL;
         end else begin
            verdict = WV_TAKE;
         end
      end
   end

   assign cr_we_o = (verdict == WV_TAKE);
   assign sr_we_o = valid_i && write_i && sr_hit;
   assign ready_o = (verdict != WV_STALL);
   assign err_o   = (verdict == WV_ERR);
endmodule

// File: rtl/fctl_ctrl_reg.sv
module fctl_ctrl_reg
   import fctl_pkg::*;
#(
   parameter int unsigned PNB_W = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic              susp_i,
   input  logic              op_end_i,
   input  logic              unlock_i,
   input  logic              opt_unlock_i,
   output logic [DATA_W-1:0] cr_q,
   output logic              pend_q
);
   localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
   localparam logic [DATA_W-1:0] PNB_MASK  = ((ONE << PNB_W) - ONE) << B_PNB;
   localparam logic [DATA_W-1:0] RW_MASK   = (ONE << B_PG) | (ONE << B_PER) | (ONE << B_MER)
                                           | PNB_MASK | (ONE << B_EOPIE) | (ONE << B_ERRIE);
   localparam logic [DATA_W-1:0] LOCK_MASK = (ONE << B_OPTLOCK) | (ONE << B_LOCK);
   localparam logic [DATA_W-1:0] SET_MASK  = LOCK_MASK | (ONE << B_STRT);
   localparam logic [DATA_W-1:0] RST_VAL   = LOCK_MASK;

   logic [DATA_W-1:0] lane_mask;
   logic [DATA_W-1:0] rw_eff, set_eff, cr_d;
   logic              locked, start_req, pend_d;

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign lane_mask[8*g +: 8] = {8{be_i[g]}};
   end

   assign locked    = cr_q[B_LOCK];
   assign rw_eff    = locked ? '0 : (RW_MASK & lane_mask);
   assign set_eff   = (locked ? LOCK_MASK : SET_MASK) & lane_mask;
   assign start_req = we_i && set_eff[B_STRT] && wdata_i[B_STRT];

   always_comb begin
      cr_d = cr_q;
      // hardware clears come first so that a same-cycle software set wins
      if (op_end_i)     cr_d[B_STRT]    = 1'b0;
      if (unlock_i)     cr_d[B_LOCK]    = 1'b0;
      if (opt_unlock_i) cr_d[B_OPTLOCK] = 1'b0;
      if (we_i) begin
         cr_d = (cr_d & ~rw_eff) | (wdata_i & rw_eff);
         cr_d = cr_d | (wdata_i & set_eff);
      end
   end

   always_comb begin
      if (!susp_i) begin
         pend_d = 1'b0;
      end else begin
         pend_d = pend_q | start_req;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cr_q   <= RST_VAL;
         pend_q <= 1'b0;
      end else begin
         cr_q   <= cr_d;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/fctl_status.sv
module fctl_status (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic op_ok_i,
   input  logic op_fail_i,
   input  logic eopie_i,
   input  logic errie_i,
   input  logic clr_eop_i,
   input  logic clr_err_i,
   output logic eop_q,
   output logic operr_q
);
   logic eop_d, operr_d;

   // a hardware set outranks a software clear in the same cycle
   assign eop_d   = (op_ok_i && eopie_i)   || (eop_q   && !clr_eop_i);
   assign operr_d = (op_fail_i && errie_i) || (operr_q && !clr_err_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         eop_q   <= 1'b0;
         operr_q <= 1'b0;
      end else begin
         eop_q   <= eop_d;
         operr_q <= operr_d;
      end
   end
endmodule

// File: rtl/fctl_regif.sv
module fctl_regif
   import fctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CR_OFF = 'h14,
   parameter int unsigned SR_OFF = 'h10,
   parameter int unsigned PNB_W  = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   input  logic [3:0]        bus_be_i,
   output logic              bus_ready_o,
   output logic              bus_err_o,
   output logic [31:0]       bus_rdata_o,
   input  logic              op_busy_i,
   input  logic              op_ok_i,
   input  logic              op_fail_i,
   input  logic              susp_i,
   input  logic              cfg_busy_i,
   input  logic              unlock_i,
   input  logic              opt_unlock_i,
   output logic              prog_o,
   output logic              page_erase_o,
   output logic              mass_erase_o,
   output logic [PNB_W-1:0]  page_num_o,
   output logic              launch_o,
   output logic              busy_o,
   output logic              irq_eop_o,
   output logic              irq_err_o
);
   if (PNB_W < 1 || PNB_W > 13) begin : g_bad_pnb
      $error("PNB_W must lie in 1..13 to fit below the start bit");
   end
   if (CR_OFF >= (1 << ADDR_W) || SR_OFF >= (1 << ADDR_W)) begin : g_bad_off
      $error("register offsets must fit in ADDR_W bits");
   end
   if (CR_OFF == SR_OFF) begin : g_bad_alias
      $error("control and status offsets must differ");
   end

   logic              cr_we, sr_we;
   logic [DATA_W-1:0] cr_q;
   logic              pend_q;
   logic              eop_q, operr_q;
   logic [DATA_W-1:0] sr_vec;
   logic              strt;

   fctl_wr_gate #(
      .ADDR_W (ADDR_W),
      .CR_OFF (CR_OFF),
      .SR_OFF (SR_OFF)
   ) u_gate (
      .valid_i    (bus_valid_i),
      .write_i    (bus_write_i),
      .addr_i     (bus_addr_i),
      .cfg_busy_i (cfg_busy_i),
      .susp_i     (susp_i),
      .op_busy_i  (op_busy_i),
      .cr_we_o    (cr_we),
      .sr_we_o    (sr_we),
      .ready_o    (bus_ready_o),
      .err_o      (bus_err_o)
   );

   fctl_ctrl_reg #(
      .PNB_W (PNB_W)
   ) u_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .we_i         (cr_we),
      .wdata_i      (bus_wdata_i),
      .be_i         (bus_be_i),
      .susp_i       (susp_i),
      .op_end_i     (op_ok_i || op_fail_i),
      .unlock_i     (unlock_i),
      .opt_unlock_i (opt_unlock_i),
      .cr_q         (cr_q),
      .pend_q       (pend_q)
   );

   fctl_status u_stat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .op_ok_i   (op_ok_i),
      .op_fail_i (op_fail_i),
      .eopie_i   (cr_q[B_EOPIE]),
      .errie_i   (cr_q[B_ERRIE]),
      .clr_eop_i (sr_we && bus_be_i[0] && bus_wdata_i[S_EOP]),
      .clr_err_i (sr_we && bus_be_i[0] && bus_wdata_i[S_OPERR]),
      .eop_q     (eop_q),
      .operr_q   (operr_q)
   );

   assign strt = cr_q[B_STRT];

   always_comb begin
      sr_vec           = '0;
      sr_vec[S_EOP]    = eop_q;
      sr_vec[S_OPERR]  = operr_q;
      sr_vec[S_BSY]    = busy_o;
      sr_vec[S_CFGBSY] = cfg_busy_i;
      sr_vec[S_SUSP]   = susp_i;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_valid_i && !bus_write_i) begin
         if (bus_addr_i == ADDR_W'(CR_OFF)) begin
            bus_rdata_o = cr_q;
         end else if (bus_addr_i == ADDR_W'(SR_OFF)) begin
            bus_rdata_o = sr_vec;
         end
      end
   end

   assign prog_o       = cr_q[B_PG];
   assign page_erase_o = cr_q[B_PER];
   assign mass_erase_o = cr_q[B_MER];
   assign page_num_o   = cr_q[B_PNB +: PNB_W];
   assign launch_o     = strt && !pend_q;
   assign busy_o       = op_busy_i || strt;
   assign irq_eop_o    = eop_q && cr_q[B_EOPIE];
   assign irq_err_o    = operr_q && cr_q[B_ERRIE];
endmodule

// File: rtl/fctl_regif_chk.sv
module fctl_regif_chk
   import fctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CR_OFF = 'h14,
   parameter int unsigned PNB_W  = 7
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_valid_i,
   input logic              bus_write_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_ready_o,
   input logic              bus_err_o,
   input logic              op_busy_i,
   input logic              op_ok_i,
   input logic              op_fail_i,
   input logic              susp_i,
   input logic              cfg_busy_i,
   input logic              unlock_i,
   input logic              opt_unlock_i,
   input logic [31:0]       cr_q,
   input logic              pend_q,
   input logic              eop_q,
   input logic              operr_q,
   input logic              launch_o
);
   localparam logic [31:0] ONE     = 32'd1;
   localparam logic [31:0] RW_MASK = (ONE << B_PG) | (ONE << B_PER) | (ONE << B_MER)
                                   | (((ONE << PNB_W) - ONE) << B_PNB)
                                   | (ONE << B_EOPIE) | (ONE << B_ERRIE);

   logic cr_wr;
   assign cr_wr = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(CR_OFF));

   a_r2_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cr_wr && cfg_busy_i && !susp_i) |-> !bus_ready_o);

   a_r3_err_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cr_wr && susp_i && op_busy_i) |-> (bus_ready_o && bus_err_o));

   a_r3_cr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cr_wr && susp_i && op_busy_i && !op_ok_i && !op_fail_i && !unlock_i && !opt_unlock_i)
      |=> (cr_q == $past(cr_q)));

   a_r4_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q |-> !launch_o);

   a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !susp_i |=> !pend_q);

   a_r5_err_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!operr_q && !(op_fail_i && cr_q[B_ERRIE])) |=> !operr_q);

   a_r6_eop_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!eop_q && !(op_ok_i && cr_q[B_EOPIE])) |=> !eop_q);

   a_r9_strt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((op_ok_i || op_fail_i) && !cr_wr) |=> !cr_q[B_STRT]);

   a_r12_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cr_q[B_LOCK] |=> ((cr_q & RW_MASK) == ($past(cr_q) & RW_MASK)));
endmodule

bind fctl_regif fctl_regif_chk #(
   .ADDR_W (ADDR_W),
   .CR_OFF (CR_OFF),
   .PNB_W  (PNB_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .bus_valid_i  (bus_valid_i),
   .bus_write_i  (bus_write_i),
   .bus_addr_i   (bus_addr_i),
   .bus_ready_o  (bus_ready_o),
   .bus_err_o    (bus_err_o),
   .op_busy_i    (op_busy_i),
   .op_ok_i      (op_ok_i),
   .op_fail_i    (op_fail_i),
   .susp_i       (susp_i),
   .cfg_busy_i   (cfg_busy_i),
   .unlock_i     (unlock_i),
   .opt_unlock_i (opt_unlock_i),
   .cr_q         (cr_q),
   .pend_q       (pend_q),
   .eop_q        (eop_q),
   .operr_q      (operr_q),
   .launch_o     (launch_o)
);

// File: tb/fctl_regif_tb_top.sv
module fctl_regif_tb_top;
   localparam logic [7:0] A_CR = 8'h14;
   localparam logic [7:0] A_SR = 8'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0, write = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  be = '0;
   logic        ready, err;
   logic [31:0] rdata;
   logic        op_busy = 1'b0, op_ok = 1'b0, op_fail = 1'b0;
   logic        susp = 1'b0, cfg_busy = 1'b0, unlock = 1'b0, opt_unlock = 1'b0;
   logic        prog, per, mer, launch, busy, irq_eop, irq_err;
   logic [6:0]  pnum;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fctl_regif dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .bus_valid_i (valid), .bus_write_i (write), .bus_addr_i (addr),
      .bus_wdata_i (wdata), .bus_be_i (be),
      .bus_ready_o (ready), .bus_err_o (err), .bus_rdata_o (rdata),
      .op_busy_i (op_busy), .op_ok_i (op_ok), .op_fail_i (op_fail),
      .susp_i (susp), .cfg_busy_i (cfg_busy),
      .unlock_i (unlock), .opt_unlock_i (opt_unlock),
      .prog_o (prog), .page_erase_o (per), .mass_erase_o (mer),
      .page_num_o (pnum), .launch_o (launch), .busy_o (busy),
      .irq_eop_o (irq_eop), .irq_err_o (irq_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d,
                         input logic [3:0] b, output logic e);
      @(negedge clk);
      valid = 1'b1; write = 1'b1; addr = a; wdata = d; be = b;
      #1;
      while (!ready) begin
         @(negedge clk);
         #1;
      end
      e = err;
      @(negedge clk);
      valid = 1'b0; write = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      valid = 1'b1; write = 1'b0; addr = a;
      #1;
      d = rdata;
      valid = 1'b0;
   endtask

   // which: 0 ok, 1 fail, 2 unlock, 3 opt_unlock
   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: op_ok = 1'b1;
         1: op_fail = 1'b1;
         2: unlock = 1'b1;
         default: opt_unlock = 1'b1;
      endcase
      @(negedge clk);
      op_ok = 1'b0; op_fail = 1'b0; unlock = 1'b0; opt_unlock = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      #1;
      chk("R1 ready idle", {31'd0, ready}, 32'd1);
      chk("R1 launch", {31'd0, launch}, 32'd0);
      bus_rd(A_CR, d); chk("R1 control reset", d, 32'hC000_0000);
      bus_rd(A_SR, d); chk("R1 status reset", d, 32'h0);
   endtask

   task automatic t_locked();
      logic e; logic [31:0] d;
      bus_wr(A_CR, 32'h0301_03FF, 4'hF, e);
      chk("R12 no error while locked", {31'd0, e}, 32'd0);
      bus_rd(A_CR, d); chk("R12 write ignored while locked", d, 32'hC000_0000);
      bus_wr(A_CR, 32'h0, 4'hF, e);
      bus_rd(A_CR, d); chk("R9 zero to lock bits no effect", d, 32'hC000_0000);
      pulse(2);
      bus_rd(A_CR, d); chk("R9 unlock clears LOCK", d, 32'h4000_0000);
      pulse(3);
      bus_rd(A_CR, d); chk("R9 opt unlock clears OPTLOCK", d, 32'h0);
   endtask

   task automatic t_fields();
      logic e; logic [31:0] d;
      bus_wr(A_CR, 32'h0300_0027, 4'hF, e);
      bus_rd(A_CR, d); chk("R8 readback", d, 32'h0300_0027);
      #1;
      chk("R8 mode outputs", {29'd0, mer, per, prog}, 32'h7);
      chk("R8 page number", {25'd0, pnum}, 32'd4);
      bus_wr(A_CR, 32'h3CFE_FC00, 4'hF, e);
      bus_rd(A_CR, d); chk("R10 reserved bits", d, 32'h0);
   endtask

   task automatic t_bytes();
      logic e; logic [31:0] d;
      bus_wr(A_CR, 32'h0300_0027, 4'hF, e);
      bus_wr(A_CR, 32'h0, 4'b0001, e);
      bus_rd(A_CR, d); chk("R7 byte 0 only", d, 32'h0300_0000);
      bus_wr(A_CR, 32'hFFFF_03FF, 4'b0010, e);
      bus_rd(A_CR, d); chk("R7 byte 1 only", d, 32'h0300_0300);
      bus_wr(A_CR, 32'h0, 4'b1000, e);
      bus_rd(A_CR, d); chk("R7 byte 3 only", d, 32'h0000_0300);
      bus_wr(A_CR, 32'h0, 4'hF, e);
   endtask

   task automatic t_start();
      logic e; logic [31:0] d;
      bus_wr(A_CR, 32'h0001_0001, 4'hF, e);
      #1;
      chk("R9 start launches", {30'd0, launch, busy}, 32'h3);
      bus_wr(A_CR, 32'h0, 4'hF, e);
      bus_rd(A_CR, d); chk("R9 zero to START no effect", d, 32'h0001_0000);
      bus_rd(A_SR, d); chk("R13 busy bit from START", d, 32'h0001_0000);
      pulse(0);
      #1;
      chk("R9 START cleared by completion", {30'd0, launch, busy}, 32'h0);
      bus_rd(A_SR, d); chk("R6 no EOP without enable", d, 32'h0);
   endtask

   task automatic t_flags();
      logic e; logic [31:0] d;
      bus_wr(A_CR, 32'h0300_0000, 4'hF, e);
      pulse(0);
      bus_rd(A_SR, d); chk("R6 EOP set", d, 32'h1);
      #1; chk("R11 eop irq", {30'd0, irq_err, irq_eop}, 32'h1);
      pulse(1);
      bus_rd(A_SR, d); chk("R5 OPERR set", d, 32'h3);
      #1; chk("R11 both irqs", {30'd0, irq_err, irq_eop}, 32'h3);
      bus_wr(A_SR, 32'h1, 4'hF, e);
      bus_rd(A_SR, d); chk("R6 EOP write-1 clear", d, 32'h2);
      bus_wr(A_SR, 32'h2, 4'hF, e);
      bus_rd(A_SR, d); chk("R5 OPERR write-1 clear", d, 32'h0);
      #1; chk("R11 irqs low", {30'd0, irq_err, irq_eop}, 32'h0);
      bus_wr(A_CR, 32'h0100_0000, 4'hF, e);
      pulse(1);
      bus_rd(A_SR, d); chk("R5 no OPERR without enable", d, 32'h0);
      bus_wr(A_CR, 32'h0, 4'hF, e);
   endtask

   task automatic t_stall();
      logic [31:0] d;
      cfg_busy = 1'b1;
      bus_rd(A_SR, d); chk("R13 config busy bit", d, 32'h0002_0000);
      @(negedge clk);
      valid = 1'b1; write = 1'b1; addr = A_CR; wdata = 32'h4; be = 4'hF;
      #1; chk("R2 stalled", {31'd0, ready}, 32'd0);
      repeat (3) @(negedge clk);
      #1; chk("R2 still stalled", {31'd0, ready}, 32'd0);
      chk("R2 no update during stall", {31'd0, mer}, 32'd0);
      @(negedge clk);
      cfg_busy = 1'b0;
      #1; chk("R2 released", {30'd0, ready, err}, 32'h2);
      @(negedge clk);
      valid = 1'b0; write = 1'b0;
      chk("R2 write lands", {31'd0, mer}, 32'd1);
   endtask

   task automatic t_err();
      logic e; logic [31:0] d;
      susp = 1'b1; op_busy = 1'b1;
      bus_rd(A_SR, d); chk("R13 busy and suspend bits", d, 32'h0005_0000);
      bus_wr(A_CR, 32'h0001_0001, 4'hF, e);
      chk("R3 error response", {31'd0, e}, 32'd1);
      bus_rd(A_CR, d); chk("R3 control unchanged", d, 32'h4);
      susp = 1'b0; op_busy = 1'b0;
   endtask

   task automatic t_susp();
      logic e; logic [31:0] d;
      bus_wr(A_CR, 32'h0, 4'hF, e);
      @(negedge clk); susp = 1'b1;
      bus_wr(A_CR, 32'h0001_0002, 4'hF, e);
      chk("R4 accepted without error", {31'd0, e}, 32'd0);
      bus_rd(A_CR, d); chk("R4 request stored", d, 32'h0001_0002);
      #1; chk("R4 held: launch 0, busy 1", {30'd0, launch, busy}, 32'h1);
      repeat (3) @(negedge clk);
      #1; chk("R4 still held", {31'd0, launch}, 32'd0);
      @(negedge clk); susp = 1'b0;
      #1; chk("R4 not yet released", {31'd0, launch}, 32'd0);
      @(negedge clk);
      #1; chk("R4 launch after release", {31'd0, launch}, 32'd1);
      op_busy = 1'b1;
      repeat (2) @(negedge clk);
      op_busy = 1'b0;
      pulse(0);
      #1; chk("R4 completes", {30'd0, launch, busy}, 32'h0);
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_locked();
      t_fields();
      t_bytes();
      t_start();
      t_flags();
      t_stall();
      t_err();
      t_susp();
      done = 1'b1;
      finish_up();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end
endmodule